// File: doc/BRIEF.md
# Parallel DAC Bus Write Sequencer

This block sits on the host side of a double-buffered parallel converter. It takes one request on a plain port and turns it into the select, write, load and clear waveforms the converter needs. A request carries a 16-bit code and three options. The first chooses a single full-width write or two byte-wide writes over a shared 8-bit bus. The second chooses which byte goes first. The third either pulses the load strobe at the end or leaves the load for later, so that several converters can be updated together by one separate load request.

Every minimum low time and setup time is given as a time parameter in picoseconds. The block converts each one to clock cycles by rounding up. After reset the block holds itself busy for a power-up lockout, and no select can go low during that time. While a transfer runs, `busy_o` is high. `done_o` pulses for one cycle when the transfer finishes.

Top module: `pdac_seq`

## Requirements
- R1: While `rst_ni` is low, all five strobes (`cs_lo_n_o`, `cs_hi_n_o`, `wr_n_o`, `load_n_o`, `clear_n_o`) are high, `bus_o` is 0, `busy_o` is 1 and `done_o` is 0.
- R2: After reset is released, `busy_o` stays high for exactly PU_CYC = ceil(T_PU_PS/CLK_PS) samples, one after each of the first PU_CYC rising edges. During that time no select goes low and every request is ignored.
- R3: A full-width write drives `cs_lo_n_o`, `cs_hi_n_o` and `wr_n_o` low together and puts the whole code on `bus_o`.
- R4: A byte-wide write makes two write pulses with exactly one select low in each. `cs_lo_n_o` low carries code[7:0] and `cs_hi_n_o` low carries code[15:8], and the byte is copied onto both halves of `bus_o`. With `hi_first_i`=1 the upper byte goes first, otherwise the lower byte goes first. Between the two pulses `wr_n_o` is high for at least one cycle.
- R5: Each write pulse keeps its select(s) and `wr_n_o` low for exactly WR_CYC cycles. WR_CYC is the largest of the rounded-up select width, write width and data setup time, and is 4 at the defaults. `bus_o` does not change while `wr_n_o` is low.
- R6: Without defer, a write ends with one `load_n_o` low pulse of LD_CYC cycles (4 at the defaults), after `wr_n_o` has returned high.
- R7: With `defer_i`=1, no load pulse follows the write. A later `load_req_i` while idle makes exactly one `load_n_o` pulse of LD_CYC cycles.
- R8: `clear_req_i` while idle makes one `clear_n_o` low pulse of CLR_CYC cycles (4 at the defaults) and no other strobe. When several requests arrive in the same cycle, clear wins over write, and write wins over load. At most one of write, load and clear is low at any time.
- R9: Any request that arrives while `busy_o` is high is ignored and makes no strobe.
- R10: `done_o` is high for exactly one cycle after each write, load or clear. In that cycle `busy_o` is already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_req_i | input | 1 | Write request, sampled when idle |
| code_i | input | DATA_W | Code to write |
| byte_mode_i | input | 1 | 1: two byte-wide writes, 0: one full-width write |
| hi_first_i | input | 1 | Byte mode: 1 sends the upper byte first |
| defer_i | input | 1 | 1: skip the load pulse at the end of the write |
| load_req_i | input | 1 | Standalone load request |
| clear_req_i | input | 1 | Clear request |
| cs_lo_n_o | output | 1 | Lower-byte select, active low |
| cs_hi_n_o | output | 1 | Upper-byte select, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| load_n_o | output | 1 | Load strobe, active low |
| clear_n_o | output | 1 | Clear pulse, active low |
| bus_o | output | DATA_W | Data bus |
| busy_o | output | 1 | A transfer or the lockout is in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
All outputs are registered straight from the next-state decode, so a wrong state or a wrong lane shows on the strobes one clock edge later. The possible symptoms are:
- a select in the wrong phase;
- a byte on the wrong half of the bus;
- a pulse that is one cycle short or long;
- a load strobe that should not be there.

A bad timer or a bad lockout count shows up as a wrong pulse width, or as `busy_o` falling at the wrong cycle after reset. Every strobe rise is compared in the bench with a queued expected event, so an extra or missing event is caught at the next edge of that strobe.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  typedef enum logic [2:0] {ST_BOOT, ST_IDLE, ST_WR, ST_GAP, ST_LOAD, ST_CLR} seq_st_e;
  typedef enum logic [1:0] {LN_NONE, LN_LO, LN_HI, LN_BOTH} lane_e;

  function automatic int cyc_ceil(int t_ps, int clk_ps);
    return (t_ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pdac_lockout.sv
module pdac_lockout #(
  parameter int PU_CYC = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic done_o
);
  localparam int CW = $clog2(PU_CYC + 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (!done_q) begin
      if (cnt_q == CW'(PU_CYC - 1)) done_q <= 1'b1;
      else                          cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;

  // R2
  lockout_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);
endmodule

// File: rtl/pdac_tick.sv
module pdac_tick #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i - 1'b1;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = (cnt_q == '0);

  // R5
  tick_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (val_i != '0));
endmodule

// File: rtl/pdac_lane_mux.sv
module pdac_lane_mux
  import pdac_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  lane_e             lane_i,
  input  logic [DATA_W-1:0] code_i,
  output logic              cs_lo_n_o,
  output logic              cs_hi_n_o,
  output logic [DATA_W-1:0] bus_o
);
  localparam int BYTE_W = DATA_W / 2;

  logic [BYTE_W-1:0] lo_b, hi_b;
  assign lo_b = code_i[BYTE_W-1:0];
  assign hi_b = code_i[DATA_W-1:BYTE_W];

  always_comb begin
    cs_lo_n_o = 1'b1;
    cs_hi_n_o = 1'b1;
    bus_o     = code_i;
    unique case (lane_i)
      LN_LO:   begin cs_lo_n_o = 1'b0; bus_o = {lo_b, lo_b}; end
      LN_HI:   begin cs_hi_n_o = 1'b0; bus_o = {hi_b, hi_b}; end
      LN_BOTH: begin cs_lo_n_o = 1'b0; cs_hi_n_o = 1'b0; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pdac_seq.sv
module pdac_seq
  import pdac_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int CLK_PS    = 10000,
  parameter int T_CS_PS   = 40000,
  parameter int T_WR_PS   = 40000,
  parameter int T_DS_PS   = 40000,
  parameter int T_LD_PS   = 40000,
  parameter int T_CLR_PS  = 40000,
  parameter int T_PU_PS   = 10000000,
  parameter int GAP_CYC   = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_req_i,
  input  logic [DATA_W-1:0] code_i,
  input  logic              byte_mode_i,
  input  logic              hi_first_i,
  input  logic              defer_i,
  input  logic              load_req_i,
  input  logic              clear_req_i,
  output logic              cs_lo_n_o,
  output logic              cs_hi_n_o,
  output logic              wr_n_o,
  output logic              load_n_o,
  output logic              clear_n_o,
  output logic [DATA_W-1:0] bus_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int WR_CYC  = imax(imax(cyc_ceil(T_CS_PS, CLK_PS), cyc_ceil(T_WR_PS, CLK_PS)),
                                imax(cyc_ceil(T_DS_PS, CLK_PS), 1));
  localparam int LD_CYC  = imax(cyc_ceil(T_LD_PS, CLK_PS), 1);
  localparam int CLR_CYC = imax(cyc_ceil(T_CLR_PS, CLK_PS), 1);
  localparam int PU_CYC  = imax(cyc_ceil(T_PU_PS, CLK_PS), 1);
  localparam int GP_CYC  = imax(GAP_CYC, 1);
  localparam int TW      = $clog2(imax(imax(WR_CYC, LD_CYC), imax(CLR_CYC, GP_CYC)) + 1);

  seq_st_e           state_q, state_d;
  lane_e             lane_q, lane_d;
  logic [DATA_W-1:0] code_q, code_d;
  logic              hi_first_q, hi_first_d;
  logic              pend2_q, pend2_d;
  logic              ld_pend_q, ld_pend_d;
  logic              byte_q, byte_d;
  logic              done_d;
  logic              tmr_load, tmr_exp;
  logic [TW-1:0]     tmr_val;
  logic              boot_done;

  pdac_lockout #(.PU_CYC(PU_CYC)) u_lockout (
    .clk_i, .rst_ni, .done_o(boot_done)
  );

  pdac_tick #(.W(TW)) u_tick (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .expire_o(tmr_exp)
  );

  always_comb begin
    state_d    = state_q;
    lane_d     = lane_q;
    code_d     = code_q;
    hi_first_d = hi_first_q;
    pend2_d    = pend2_q;
    ld_pend_d  = ld_pend_q;
    byte_d     = byte_q;
    done_d     = 1'b0;
    tmr_load   = 1'b0;
    tmr_val    = '0;
    unique case (state_q)
      ST_BOOT: if (boot_done) state_d = ST_IDLE;
      ST_IDLE: begin
        if (clear_req_i) begin
          state_d  = ST_CLR;
          tmr_load = 1'b1;
          tmr_val  = TW'(CLR_CYC);
        end else if (wr_req_i) begin
          state_d    = ST_WR;
          code_d     = code_i;
          hi_first_d = hi_first_i;
          byte_d     = byte_mode_i;
          pend2_d    = byte_mode_i;
          ld_pend_d  = !defer_i;
          lane_d     = !byte_mode_i ? LN_BOTH : (hi_first_i ? LN_HI : LN_LO);
          tmr_load   = 1'b1;
          tmr_val    = TW'(WR_CYC);
        end else if (load_req_i) begin
          state_d  = ST_LOAD;
          tmr_load = 1'b1;
          tmr_val  = TW'(LD_CYC);
        end
      end
      ST_WR: if (tmr_exp) begin
        state_d  = ST_GAP;
        lane_d   = LN_NONE;
        tmr_load = 1'b1;
        tmr_val  = TW'(GP_CYC);
      end
      ST_GAP: if (tmr_exp) begin
        if (pend2_q) begin
          state_d  = ST_WR;
          pend2_d  = 1'b0;
          lane_d   = hi_first_q ? LN_LO : LN_HI;
          tmr_load = 1'b1;
          tmr_val  = TW'(WR_CYC);
        end else if (ld_pend_q) begin
          state_d   = ST_LOAD;
          ld_pend_d = 1'b0;
          tmr_load  = 1'b1;
          tmr_val   = TW'(LD_CYC);
        end else begin
          state_d = ST_IDLE;
          byte_d  = 1'b0;
          done_d  = 1'b1;
        end
      end
      ST_LOAD, ST_CLR: if (tmr_exp) begin
        state_d = ST_IDLE;
        byte_d  = 1'b0;
        done_d  = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_BOOT;
      lane_q     <= LN_NONE;
      code_q     <= '0;
      hi_first_q <= 1'b0;
      pend2_q    <= 1'b0;
      ld_pend_q  <= 1'b0;
      byte_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      lane_q     <= lane_d;
      code_q     <= code_d;
      hi_first_q <= hi_first_d;
      pend2_q    <= pend2_d;
      ld_pend_q  <= ld_pend_d;
      byte_q     <= byte_d;
    end
  end

  // registered strobes, decoded from next state
  lane_e             mux_lane;
  logic              mux_cs_lo_n, mux_cs_hi_n;
  logic [DATA_W-1:0] mux_bus;
  logic              cs_lo_n_q, cs_hi_n_q, wr_n_q, load_n_q, clear_n_q, done_q;
  logic [DATA_W-1:0] bus_q;

  assign mux_lane = (state_d == ST_WR) ? lane_d : LN_NONE;

  pdac_lane_mux #(.DATA_W(DATA_W)) u_lane (
    .lane_i(mux_lane), .code_i(code_d),
    .cs_lo_n_o(mux_cs_lo_n), .cs_hi_n_o(mux_cs_hi_n), .bus_o(mux_bus)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_lo_n_q <= 1'b1;
      cs_hi_n_q <= 1'b1;
      wr_n_q    <= 1'b1;
      load_n_q  <= 1'b1;
      clear_n_q <= 1'b1;
      bus_q     <= '0;
      done_q    <= 1'b0;
    end else begin
      cs_lo_n_q <= mux_cs_lo_n;
      cs_hi_n_q <= mux_cs_hi_n;
      wr_n_q    <= (state_d != ST_WR);
      load_n_q  <= (state_d != ST_LOAD);
      clear_n_q <= (state_d != ST_CLR);
      if (state_d == ST_WR) bus_q <= mux_bus;
      done_q    <= done_d;
    end
  end

  assign cs_lo_n_o = cs_lo_n_q;
  assign cs_hi_n_o = cs_hi_n_q;
  assign wr_n_o    = wr_n_q;
  assign load_n_o  = load_n_q;
  assign clear_n_o = clear_n_q;
  assign bus_o     = bus_q;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;

  // checker counters
  localparam int PW = $clog2(PU_CYC + 1);
  localparam int WW = $clog2(WR_CYC + 2);
  logic [PW-1:0] since_q;
  logic [WW-1:0] wr_lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= '0;
      wr_lo_q <= '0;
    end else begin
      if (since_q != PW'(PU_CYC)) since_q <= since_q + 1'b1;
      if (wr_n_o)                 wr_lo_q <= '0;
      else if (wr_lo_q != WW'(WR_CYC + 1)) wr_lo_q <= wr_lo_q + 1'b1;
    end
  end

  // R2
  lockout_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_lo_n_o || !cs_hi_n_o) |-> (since_q == PW'(PU_CYC)));
  // R3
  sel_in_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_lo_n_o || !cs_hi_n_o) |-> !wr_n_o);
  // R4
  byte_one_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_q && !wr_n_o) |-> (cs_lo_n_o != cs_hi_n_o));
  // R5
  wr_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_n_o) |-> (wr_lo_q == WW'(WR_CYC)));
  // R5
  bus_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_n_o && $past(!wr_n_o)) |-> $stable(bus_o));
  // R8
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({!wr_n_o, !load_n_o, !clear_n_o}) <= 1);
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/pdac_seq_tb.sv
module pdac_seq_tb;
  localparam int CLK_PS = 10000;
  localparam int WR_EXP = (40000 + CLK_PS - 1) / CLK_PS;
  localparam int LD_EXP = (40000 + CLK_PS - 1) / CLK_PS;
  localparam int CL_EXP = (40000 + CLK_PS - 1) / CLK_PS;
  localparam int PU_EXP = (10000000 + CLK_PS - 1) / CLK_PS;
  localparam int K_WR = 0, K_LD = 1, K_CL = 2;

  typedef struct {
    int          kind;
    logic        cs_lo_n;
    logic        cs_hi_n;
    logic [15:0] data;
    int          width;
    string       tag;
  } item_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_req = 0, byte_m = 0, hi_first = 0, defer = 0, load_req = 0, clear_req = 0;
  logic [15:0] code = '0;
  logic cs_lo_n, cs_hi_n, wr_n, load_n, clear_n, busy, done;
  logic [15:0] bus;

  item_t exp_q[$];
  int n_cmp = 0, n_mis = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pdac_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_req_i(wr_req), .code_i(code),
    .byte_mode_i(byte_m), .hi_first_i(hi_first), .defer_i(defer),
    .load_req_i(load_req), .clear_req_i(clear_req),
    .cs_lo_n_o(cs_lo_n), .cs_hi_n_o(cs_hi_n), .wr_n_o(wr_n),
    .load_n_o(load_n), .clear_n_o(clear_n), .bus_o(bus),
    .busy_o(busy), .done_o(done)
  );

  task automatic chk(bit ok, string tag, int act, int exp_v);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp_v);
    end
  endtask

  // monitor
  logic p_wr = 1, p_ld = 1, p_cl = 1, p_cslo = 1, p_cshi = 1;
  logic [15:0] p_bus = '0;
  int w_wr = 0, w_ld = 0, w_cl = 0;
  bit moved = 0;

  task automatic score(item_t act);
    item_t e;
    if (exp_q.size() == 0) begin
      chk(0, "R9 unexpected strobe", act.kind, -1);
      return;
    end
    e = exp_q.pop_front();
    chk(act.kind == e.kind, {e.tag, " kind"}, act.kind, e.kind);
    chk(act.width == e.width, {e.tag, " width"}, act.width, e.width);
    if (e.kind == K_WR) begin
      chk({act.cs_lo_n, act.cs_hi_n} == {e.cs_lo_n, e.cs_hi_n}, {e.tag, " selects"},
          {act.cs_lo_n, act.cs_hi_n}, {e.cs_lo_n, e.cs_hi_n});
      chk(act.data == e.data, {e.tag, " data"}, act.data, e.data);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      item_t a;
      if (p_wr === 1'b0 && wr_n === 1'b1) begin
        a = '{K_WR, p_cslo, p_cshi, p_bus, w_wr, ""};
        score(a);
        chk(!moved, "R5 bus stable during write", 1, 0);
      end
      if (p_ld === 1'b0 && load_n === 1'b1) begin a = '{K_LD, 1, 1, '0, w_ld, ""}; score(a); end
      if (p_cl === 1'b0 && clear_n === 1'b1) begin a = '{K_CL, 1, 1, '0, w_cl, ""}; score(a); end
      if ((!cs_lo_n || !cs_hi_n) && wr_n) chk(0, "R3 select outside write", 1, 0);
      if (!wr_n) begin
        if (!p_wr && bus != p_bus) moved = 1;
        w_wr++;
      end else begin w_wr = 0; moved = 0; end
      w_ld = load_n ? 0 : w_ld + 1;
      w_cl = clear_n ? 0 : w_cl + 1;
      p_wr = wr_n; p_ld = load_n; p_cl = clear_n;
      p_cslo = cs_lo_n; p_cshi = cs_hi_n; p_bus = bus;
    end
  end

  task automatic push(int kind, logic lo_n, logic hi_n, logic [15:0] d, int w, string tag);
    item_t it;
    it = '{kind, lo_n, hi_n, d, w, tag};
    exp_q.push_back(it);
  endtask

  task automatic wait_done(string tag);
    int n;
    n = 0;
    @(negedge clk);
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk(done === 1'b1, {tag, " R10 done seen"}, done, 1);
    chk(busy === 1'b0, "R10 busy low with done", busy, 0);
    @(negedge clk);
    chk(done === 1'b0, "R10 done one cycle", done, 0);
    chk(exp_q.size() == 0, {tag, " all events seen"}, exp_q.size(), 0);
    chk({cs_lo_n, cs_hi_n, wr_n, load_n, clear_n} == 5'h1f, {tag, " idle strobes high"},
        {cs_lo_n, cs_hi_n, wr_n, load_n, clear_n}, 5'h1f);
  endtask

  task automatic do_write(logic [15:0] c, bit bm, bit hf, bit df, string tag);
    if (!bm) push(K_WR, 0, 0, c, WR_EXP, {tag, " R3 R5"});
    else if (hf) begin
      push(K_WR, 1, 0, {c[15:8], c[15:8]}, WR_EXP, {tag, " R4 hi"});
      push(K_WR, 0, 1, {c[7:0], c[7:0]}, WR_EXP, {tag, " R4 lo"});
    end else begin
      push(K_WR, 0, 1, {c[7:0], c[7:0]}, WR_EXP, {tag, " R4 lo"});
      push(K_WR, 1, 0, {c[15:8], c[15:8]}, WR_EXP, {tag, " R4 hi"});
    end
    if (!df) push(K_LD, 1, 1, '0, LD_EXP, {tag, " R6 load"});
    code = c; byte_m = bm; hi_first = hf; defer = df; wr_req = 1;
    @(negedge clk);
    wr_req = 0; code = ~c;
    wait_done(tag);
  endtask

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    // R1
    chk({cs_lo_n, cs_hi_n, wr_n, load_n, clear_n} == 5'h1f, "R1 strobes high",
        {cs_lo_n, cs_hi_n, wr_n, load_n, clear_n}, 5'h1f);
    chk(bus == 16'h0, "R1 bus zero", bus, 0);
    chk(busy == 1'b1 && done == 1'b0, "R1 busy/done", {busy, done}, 2'b10);
    rst_n = 1;
    // R2 lockout, request in lockout ignored
    nb = 0;
    @(negedge clk);
    while (busy && nb < PU_EXP + 10) begin
      if (!cs_lo_n || !cs_hi_n) chk(0, "R2 select in lockout", 0, 1);
      if (nb == 5) begin wr_req = 1; clear_req = 1; load_req = 1; end
      if (nb == 6) begin wr_req = 0; clear_req = 0; load_req = 0; end
      nb++;
      @(negedge clk);
    end
    chk(nb == PU_EXP, "R2 lockout length", nb, PU_EXP);
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0 && wr_n && clear_n && load_n, "R2 lockout requests ignored", wr_n, 1);

    do_write(16'hA5C3, 0, 0, 0, "full");
    do_write(16'h1234, 1, 0, 0, "byte lo-first");
    do_write(16'hBEEF, 1, 1, 0, "byte hi-first");
    do_write(16'h0000, 0, 0, 0, "zero code");
    do_write(16'hFFFF, 1, 0, 0, "ones code");

    // R7 deferred then load
    do_write(16'h0F0F, 0, 0, 1, "R7 defer full");
    do_write(16'h8001, 1, 1, 1, "R7 defer byte");
    push(K_LD, 1, 1, '0, LD_EXP, "R7 standalone load");
    load_req = 1; @(negedge clk); load_req = 0;
    wait_done("R7 load");

    // R8 clear and priority
    push(K_CL, 1, 1, '0, CL_EXP, "R8 clear");
    clear_req = 1; @(negedge clk); clear_req = 0;
    wait_done("R8 clear");
    push(K_CL, 1, 1, '0, CL_EXP, "R8 clear priority");
    clear_req = 1; wr_req = 1; load_req = 1; code = 16'h7777;
    @(negedge clk);
    clear_req = 0; wr_req = 0; load_req = 0;
    wait_done("R8 priority");
    push(K_WR, 0, 0, 16'h6666, WR_EXP, "R8 write over load");
    wr_req = 1; load_req = 1; code = 16'h6666; byte_m = 0; defer = 1;
    @(negedge clk);
    wr_req = 0; load_req = 0;
    wait_done("R8 write over load");

    // R9 busy ignore
    push(K_WR, 0, 0, 16'h5555, WR_EXP, "R9 write");
    push(K_LD, 1, 1, '0, LD_EXP, "R9 load");
    code = 16'h5555; byte_m = 0; defer = 0; wr_req = 1;
    @(negedge clk); wr_req = 0;
    @(negedge clk);
    code = 16'hFFFF; wr_req = 1; load_req = 1; clear_req = 1;
    @(negedge clk);
    wr_req = 0; load_req = 0; clear_req = 0;
    repeat (5) @(negedge clk);
    wr_req = 1; code = 16'h1111;
    @(negedge clk); wr_req = 0;
    wait_done("R9");
    repeat (12) @(negedge clk);
    chk(busy == 1'b0, "R9 no late transfer", busy, 0);
    chk(exp_q.size() == 0, "R9 no pending", exp_q.size(), 0);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_mis++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
      $finish;
    end
  end
endmodule